// File: doc/BRIEF.md
# Flash Save-Memory Command Controller

This block models a byte-wide flash save memory for a cartridge. A host drives it with 32-bit command words whose top byte is an opcode. Setup opcodes select a mode, set a page offset and load a 64-bit status/ID word. A separate execute opcode then either erases one 128-byte page to 0xFF or programs that page from a 128-byte page buffer. The page buffer is filled one byte at a time through a load port, and only while the block is in write mode.

Reads start with a single pulse that carries an address and a length. In read mode, the block streams array bytes starting at twice the given address, wrapping inside the array. In status mode, it streams the eight bytes of the status word, most significant first. The upper half of the status word is also visible at all times on a separate output. Misuse of the read port or the load port raises a one-cycle error pulse.

An erase or program holds a busy output for 128 cycles, one byte per cycle. Commands are held off during that time and during any read stream. The array size is a parameter: the default is 4 KiB, and 131072 gives the full 128 KiB part. The array reads as fully erased after reset.

Top module: `flash_save_ctrl`

## Requirements
- R1: After reset the mode is idle, the status word is zero, `busy` and `err` are low, `cmd_ready` and `rd_ready` are high, and every array byte reads 0xFF.
- R2: The opcode is `cmd_word[31:24]`. An accepted command whose opcode is not one of 0x4B, 0x78, 0xA5, 0xB4, 0xD2, 0xE1 or 0xF0 changes neither the mode nor the status word.
- R3: Opcodes 0x4B and 0xA5 set the page offset to `cmd_word[15:0]` × 128, reduced modulo the array size. 0xA5 also loads status 0x1111800400C20000 and keeps the mode. 0x4B changes neither the mode nor the status.
- R4: 0x78 enters erase mode and loads status 0x1111800800C20000. 0xE1 enters status mode and loads 0x1111800100C20000. 0xF0 enters read mode and loads 0x11118004F0000000. 0xB4 enters write mode, leaves the status unchanged, and restarts page-buffer loading at index 0.
- R5: Opcode 0xD2 in erase mode sets the 128 bytes starting at the page offset to 0xFF.
- R6: Opcode 0xD2 in write mode copies the page buffer to the page: the k-th byte loaded since the last 0xB4 (k from 0) lands at page offset + k.
- R7: Opcode 0xD2 in idle or status mode changes no array byte and starts no busy period. After any accepted 0xD2 the mode is idle.
- R8: An erase or program keeps `busy` high for exactly 128 cycles, starting the cycle after the execute command is accepted. `cmd_ready` is low while `busy` is high, while a read stream runs, and while `rd_start` is high.
- R9: A read in status mode returns 8 bytes on `rd_data`: status bits 63:56 first, down to bits 7:0 last. The length input is ignored.
- R10: A read in read mode returns `rd_len`+1 bytes, one per cycle with `rd_valid` high, starting at array byte (`rd_addr` × 2) modulo the array size. The address wraps from the last byte to byte 0.
- R11: A read started in a mode other than read or status returns no bytes and pulses `err` in the next cycle. A buffer load outside write mode also pulses `err` in the next cycle.
- R12: `status_hi` always equals bits 63:32 of the current status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command accepted this cycle when high together with cmd_valid |
| cmd_word | input | 32 | Command word, opcode in bits 31:24 |
| buf_valid | input | 1 | Page-buffer byte offered |
| buf_data | input | 8 | Page-buffer byte |
| rd_start | input | 1 | Start a read stream (taken when rd_ready is high) |
| rd_ready | output | 1 | Read port idle and no erase/program running |
| rd_addr | input | 16 | Read start address, in units of two bytes |
| rd_len | input | LEN_W | Read length minus one, in bytes |
| rd_valid | output | 1 | rd_data holds a read byte |
| rd_data | output | 8 | Streamed read byte |
| status_hi | output | 32 | Upper half of the status word |
| busy | output | 1 | Erase or program in progress |
| err | output | 1 | One-cycle pulse on a misused read or buffer load |

## Verification
The hardest case to reach is a read that wraps from the top of the array back to byte 0. To get there, the stimulus must first program the last page of the array and then read across the seam. The bench names the last page with a page number above the array size, so the same sequence also checks the offset masking. It then starts a read just short of the array end and checks that the tail of the programmed pattern is followed by erased bytes from page 0. A second difficult case is an execute command in status mode: only a quiet `busy` line shows that nothing happened. That the mode became idle shows only through the error pulse of a later read.

// File: rtl/flash_pkg.sv
package flash_pkg;

    localparam int PAGE_BYTES = 128;
    localparam int PAGE_LSB   = $clog2(PAGE_BYTES);

    typedef enum logic [2:0] {
        MD_IDLE,
        MD_ERASE,
        MD_WRITE,
        MD_READ,
        MD_STATUS
    } mode_e;

    localparam logic [7:0] OP_SET_PAGE    = 8'h4B;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h78;
    localparam logic [7:0] OP_PAGE_STAT   = 8'hA5;
    localparam logic [7:0] OP_WRITE_SETUP = 8'hB4;
    localparam logic [7:0] OP_EXECUTE     = 8'hD2;
    localparam logic [7:0] OP_ID_STATUS   = 8'hE1;
    localparam logic [7:0] OP_READ_SETUP  = 8'hF0;

    localparam logic [63:0] ST_ERASE = 64'h1111_8008_00C2_0000;
    localparam logic [63:0] ST_PAGE  = 64'h1111_8004_00C2_0000;
    localparam logic [63:0] ST_ID    = 64'h1111_8001_00C2_0000;
    localparam logic [63:0] ST_READ  = 64'h1111_8004_F000_0000;

    // Job handed from the decoder to the array sequencer
    typedef struct packed {
        logic start;
        logic erase;
    } job_t;

    function automatic logic op_known(input logic [7:0] op);
        return op == OP_SET_PAGE || op == OP_ERASE_SETUP || op == OP_PAGE_STAT ||
               op == OP_WRITE_SETUP || op == OP_EXECUTE || op == OP_ID_STATUS ||
               op == OP_READ_SETUP;
    endfunction

endpackage

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
    import flash_pkg::*;
#(
    parameter int PG_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  logic [7:0]      op,
    input  logic [15:0]     arg,
    output mode_e           mode_q,
    output logic [63:0]     status_q,
    output logic [PG_W-1:0] page_q,
    output job_t            job,
    output logic            wr_enter
);

    logic [PG_W-1:0] arg_page;
    logic            unused_arg;

    // Offset = arg * 128, kept modulo the array: only the low page bits survive
    assign arg_page   = arg[PG_W-1:0];
    assign unused_arg = ^arg;

    assign job.start = fire && op == OP_EXECUTE &&
                       (mode_q == MD_ERASE || mode_q == MD_WRITE);
    assign job.erase = mode_q == MD_ERASE;
    assign wr_enter  = fire && op == OP_WRITE_SETUP;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MD_IDLE;
            status_q <= '0;
            page_q   <= '0;
        end else if (fire) begin
            case (op)
                OP_SET_PAGE: page_q <= arg_page;
                OP_ERASE_SETUP: begin
                    mode_q   <= MD_ERASE;
                    status_q <= ST_ERASE;
                end
                OP_PAGE_STAT: begin
                    page_q   <= arg_page;
                    status_q <= ST_PAGE;
                end
                OP_WRITE_SETUP: mode_q <= MD_WRITE;
                OP_EXECUTE:     mode_q <= MD_IDLE;
                OP_ID_STATUS: begin
                    mode_q   <= MD_STATUS;
                    status_q <= ST_ID;
                end
                OP_READ_SETUP: begin
                    mode_q   <= MD_READ;
                    status_q <= ST_READ;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/flash_page_buf.sv
module flash_page_buf
    import flash_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                load,
    input  logic [7:0]          load_byte,
    input  logic [PAGE_LSB-1:0] rd_idx,
    output logic [7:0]          rd_byte
);

    logic [7:0]          slot_q [PAGE_BYTES];
    logic [PAGE_LSB-1:0] wr_idx;

    always_ff @(posedge clk) begin
        if (rst || restart) wr_idx <= '0;
        else if (load)      wr_idx <= wr_idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (load) slot_q[wr_idx] <= load_byte;
    end

    assign rd_byte = slot_q[rd_idx];

endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_pkg::*;
#(
    parameter int ARRAY_BYTES = 4096,
    localparam int ADDR_W = $clog2(ARRAY_BYTES),
    localparam int PG_W   = ADDR_W - PAGE_LSB,
    localparam int NPAGES = ARRAY_BYTES / PAGE_BYTES
) (
    input  logic                clk,
    input  logic                rst,
    input  job_t                job,
    input  logic [PG_W-1:0]     job_page,
    output logic [PAGE_LSB-1:0] buf_idx,
    input  logic [7:0]          buf_byte,
    output logic                busy,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [7:0]          rd_byte
);

    logic [7:0]          mem [ARRAY_BYTES];
    logic [NPAGES-1:0]   page_ok;
    logic [PAGE_LSB-1:0] cnt;
    logic                erase_q;
    logic [PG_W-1:0]     page_sel;

    assign buf_idx = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            erase_q  <= 1'b0;
            page_sel <= '0;
            page_ok  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == PAGE_LSB'(PAGE_BYTES - 1)) busy <= 1'b0;
        end else if (job.start) begin
            busy              <= 1'b1;
            cnt               <= '0;
            erase_q           <= job.erase;
            page_sel          <= job_page;
            page_ok[job_page] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (busy) mem[{page_sel, cnt}] <= erase_q ? 8'hFF : buf_byte;
    end

    // A page never touched since reset reads as erased
    assign rd_byte = page_ok[rd_addr[ADDR_W-1:PAGE_LSB]] ? mem[rd_addr] : 8'hFF;

endmodule

// File: rtl/flash_save_ctrl.sv
module flash_save_ctrl
    import flash_pkg::*;
#(
    parameter int ARRAY_BYTES = 4096,
    parameter int LEN_W       = 16,
    localparam int ADDR_W = $clog2(ARRAY_BYTES),
    localparam int PG_W   = ADDR_W - PAGE_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [31:0]      cmd_word,
    input  logic             buf_valid,
    input  logic [7:0]       buf_data,
    input  logic             rd_start,
    output logic             rd_ready,
    input  logic [15:0]      rd_addr,
    input  logic [LEN_W-1:0] rd_len,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic [31:0]      status_hi,
    output logic             busy,
    output logic             err
);

    mode_e               mode_q;
    logic [63:0]         status_q;
    logic [PG_W-1:0]     page_q;
    job_t                job;
    logic                wr_enter;
    logic                cmd_fire;
    logic                rd_fire;
    logic                buf_load;
    logic [PAGE_LSB-1:0] buf_idx;
    logic [7:0]          buf_byte;
    logic [7:0]          arr_byte;

    logic                rd_act;
    logic                rd_stat;
    logic [ADDR_W-1:0]   rd_ptr;
    logic [LEN_W-1:0]    rd_left;
    logic [2:0]          st_idx;
    logic [31:0]         start_full;
    logic                unused_bits;

    assign rd_ready  = !busy && !rd_act;
    assign cmd_ready = rd_ready && !rd_start;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign rd_fire   = rd_start && rd_ready;
    assign buf_load  = buf_valid && mode_q == MD_WRITE;

    assign start_full  = {15'd0, rd_addr, 1'b0};
    assign unused_bits = ^{cmd_word[23:16], start_full};

    flash_cmd_dec #(.PG_W(PG_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .fire     (cmd_fire),
        .op       (cmd_word[31:24]),
        .arg      (cmd_word[15:0]),
        .mode_q   (mode_q),
        .status_q (status_q),
        .page_q   (page_q),
        .job      (job),
        .wr_enter (wr_enter)
    );

    flash_page_buf u_buf (
        .clk       (clk),
        .rst       (rst),
        .restart   (wr_enter),
        .load      (buf_load),
        .load_byte (buf_data),
        .rd_idx    (buf_idx),
        .rd_byte   (buf_byte)
    );

    flash_store #(.ARRAY_BYTES(ARRAY_BYTES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .job      (job),
        .job_page (page_q),
        .buf_idx  (buf_idx),
        .buf_byte (buf_byte),
        .busy     (busy),
        .rd_addr  (rd_ptr),
        .rd_byte  (arr_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act  <= 1'b0;
            rd_stat <= 1'b0;
            rd_ptr  <= '0;
            rd_left <= '0;
            st_idx  <= '0;
        end else if (rd_act) begin
            if (rd_left == '0) begin
                rd_act <= 1'b0;
            end else begin
                rd_left <= rd_left - 1'b1;
                rd_ptr  <= rd_ptr + 1'b1;
                st_idx  <= st_idx + 1'b1;
            end
        end else if (rd_fire) begin
            if (mode_q == MD_READ) begin
                rd_act  <= 1'b1;
                rd_stat <= 1'b0;
                rd_ptr  <= start_full[ADDR_W-1:0];
                rd_left <= rd_len;
            end else if (mode_q == MD_STATUS) begin
                rd_act  <= 1'b1;
                rd_stat <= 1'b1;
                st_idx  <= '0;
                rd_left <= LEN_W'(7);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= (rd_fire && mode_q != MD_READ && mode_q != MD_STATUS) ||
                        (buf_valid && mode_q != MD_WRITE);
    end

    assign rd_valid  = rd_act;
    assign rd_data   = rd_stat ? status_q[{~st_idx, 3'b000} +: 8] : arr_byte;
    assign status_hi = status_q[63:32];

endmodule

// File: rtl/flash_save_chk.sv
module flash_save_chk
    import flash_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [7:0]  cmd_op,
    input mode_e       mode,
    input logic        busy,
    input logic        rd_valid,
    input logic        buf_valid,
    input logic        err,
    input logic [31:0] status_hi
);

    logic       fire;
    logic [7:0] busy_cnt;

    assign fire = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + 1'b1;
    end

    AST_EXEC_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
        fire && cmd_op == OP_EXECUTE && (mode == MD_ERASE || mode == MD_WRITE) |=> busy); // R8
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_cnt == 8'd128); // R8
    AST_EXEC_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        fire && cmd_op == OP_EXECUTE |=> mode == MD_IDLE); // R7
    AST_UNKNOWN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        fire && !op_known(cmd_op) |=> $stable(mode) && $stable(status_hi)); // R2
    AST_ID_STATUS: assert property (@(posedge clk) disable iff (rst)
        fire && cmd_op == OP_ID_STATUS |=> status_hi == 32'h1111_8001 && mode == MD_STATUS); // R4
    AST_STREAM_MODE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> mode == MD_READ || mode == MD_STATUS); // R10
    AST_BUF_MISUSE: assert property (@(posedge clk) disable iff (rst)
        buf_valid && mode != MD_WRITE |=> err); // R11

endmodule

bind flash_save_ctrl flash_save_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_word[31:24]),
    .mode      (mode_q),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .buf_valid (buf_valid),
    .err       (err),
    .status_hi (status_hi)
);

// File: tb/tb_flash_save_ctrl.sv
module tb_flash_save_ctrl;

    localparam int ARRAY_BYTES = 4096;
    localparam int LEN_W       = 16;
    localparam int LAST_PAGE   = ARRAY_BYTES / 128 - 1;

    // {command word, expected status_hi after it}
    localparam int NVEC = 7;
    localparam logic [63:0] VECS [NVEC] = '{
        {32'hE100_0000, 32'h1111_8001},   // R4
        {32'h1234_5678, 32'h1111_8001},   // R2 unknown opcode
        {32'h7800_0000, 32'h1111_8008},   // R4
        {32'hA500_0003, 32'h1111_8004},   // R3
        {32'hF000_0000, 32'h1111_8004},   // R4
        {32'h4B00_0001, 32'h1111_8004},   // R3 status kept
        {32'hD200_0000, 32'h1111_8004}    // R7 execute in read mode
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [31:0]      cmd_word = '0;
    logic             buf_valid = 1'b0;
    logic [7:0]       buf_data = '0;
    logic             rd_start = 1'b0;
    logic             rd_ready;
    logic [15:0]      rd_addr = '0;
    logic [LEN_W-1:0] rd_len = '0;
    logic             rd_valid;
    logic [7:0]       rd_data;
    logic [31:0]      status_hi;
    logic             busy;
    logic             err;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] got [256];
    int         got_n;
    logic       ready_in_read;

    always #2 clk = ~clk;

    flash_save_ctrl #(.ARRAY_BYTES(ARRAY_BYTES), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .buf_valid(buf_valid), .buf_data(buf_data),
        .rd_start(rd_start), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len),
        .rd_valid(rd_valid), .rd_data(rd_data), .status_hi(status_hi),
        .busy(busy), .err(err)
    );

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 3 + seed) & 255);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [31:0] w);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic load_page(input int seed);
        @(negedge clk);
        for (int i = 0; i < 128; i++) begin
            buf_valid = 1'b1;
            buf_data  = pat(i, seed);
            @(negedge clk);
        end
        buf_valid = 1'b0;
    endtask

    task automatic run_exec(input string req);
        int cyc;
        send_cmd(32'hD200_0000);
        check({req, " ready low while busy"}, {63'd0, cmd_ready}, 64'd0);
        cyc = 0;
        while (busy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
        check({req, " busy cycles"}, 64'(cyc), 64'd128);
    endtask

    task automatic do_read(input logic [15:0] a, input int len);
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
        rd_start = 1'b1;
        rd_addr  = a;
        rd_len   = LEN_W'(len);
        @(negedge clk);
        rd_start = 1'b0;
        got_n = 0;
        ready_in_read = cmd_ready;
        while (rd_valid && got_n < 256) begin
            got[got_n] = rd_data;
            got_n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] st;
        int          bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 status_hi", 64'(status_hi), 64'd0);
        check("R1 busy/err", {62'd0, busy, err}, 64'd0);
        check("R1 ready", {62'd0, cmd_ready, rd_ready}, 64'd3);

        // Table walk: command then expected upper status
        for (int v = 0; v < NVEC; v++) begin
            send_cmd(VECS[v][63:32]);
            check($sformatf("R12 vector %0d", v), 64'(status_hi), 64'(VECS[v][31:0]));
        end
        // Mode is now idle: a read must be refused (R7, R11)
        do_read(16'd0, 3);
        check("R11 read in idle gives no data", 64'(got_n), 64'd0);
        check("R11 read in idle err", {63'd0, err}, 64'd1);
        @(negedge clk);
        check("R11 err is a pulse", {63'd0, err}, 64'd0);

        // R1 erased array after reset
        send_cmd(32'hF000_0000);
        do_read(16'd0, 15);
        bad = 0;
        for (int i = 0; i < 16; i++) if (got[i] !== 8'hFF) bad++;
        check("R1 erased bytes", 64'(got_n * 1000 + bad), 64'(16 * 1000));
        check("R8 cmd_ready low during read", {63'd0, ready_in_read}, 64'd0);

        // R11 buffer load outside write mode
        @(negedge clk);
        buf_valid = 1'b1;
        buf_data  = 8'hAA;
        @(negedge clk);
        buf_valid = 1'b0;
        check("R11 load outside write err", {63'd0, err}, 64'd1);

        // R6 program page 2 with pattern seed 1
        send_cmd(32'hB400_0000);
        load_page(1);
        send_cmd(32'h4B00_0002);
        run_exec("R8 program");
        send_cmd(32'hF000_0000);
        do_read(16'd128, 127);
        bad = 0;
        for (int i = 0; i < 128; i++) if (got[i] !== pat(i, 1)) bad++;
        check("R6 programmed page", 64'(got_n * 1000 + bad), 64'(128 * 1000));
        // R10 odd start address: offset 258
        do_read(16'd129, 2);
        check("R10 partial read", {40'd0, got[0], got[1], got[2]},
              {40'd0, pat(2, 1), pat(3, 1), pat(4, 1)});

        // R5 erase page 2 again
        send_cmd(32'h4B00_0002);
        send_cmd(32'h7800_0000);
        run_exec("R8 erase");
        send_cmd(32'hF000_0000);
        do_read(16'd128, 127);
        bad = 0;
        for (int i = 0; i < 128; i++) if (got[i] !== 8'hFF) bad++;
        check("R5 erased page", 64'(got_n * 1000 + bad), 64'(128 * 1000));

        // R9 status stream
        send_cmd(32'hE100_0000);
        do_read(16'd0, 0);
        st = '0;
        for (int i = 0; i < 8; i++) st = {st[55:0], got[i]};
        check("R9 status byte count", 64'(got_n), 64'd8);
        check("R9 status bytes", st, 64'h1111_8001_00C2_0000);

        // R7 execute in status mode: no busy, then idle
        send_cmd(32'hD200_0000);
        check("R7 no busy from status", {63'd0, busy}, 64'd0);
        check("R7 status kept", 64'(status_hi), 64'h1111_8001);
        do_read(16'd0, 0);
        check("R7 mode idle after execute", {63'd0, err}, 64'd1);

        // R3 offset masking and R10 wrap at the array end
        send_cmd(32'hB400_0000);
        load_page(5);
        send_cmd(32'h4B00_0000 | 32'(LAST_PAGE + ARRAY_BYTES / 128));
        run_exec("R8 program last");
        send_cmd(32'hF000_0000);
        do_read(16'((ARRAY_BYTES - 4) / 2), 7);
        bad = 0;
        for (int i = 0; i < 4; i++) if (got[i] !== pat(124 + i, 5)) bad++;
        for (int i = 4; i < 8; i++) if (got[i] !== 8'hFF) bad++;
        check("R3 R10 wrap read", 64'(got_n * 1000 + bad), 64'(8 * 1000));

        // R3 opcode 0xA5 keeps mode (still read mode)
        send_cmd(32'hA500_0000 | 32'(LAST_PAGE));
        check("R3 A5 status", 64'(status_hi), 64'h1111_8004);
        do_read(16'(LAST_PAGE * 64), 0);
        check("R3 A5 keeps read mode", {55'd0, err, got[0]}, {55'd0, 1'b0, pat(0, 5)});

        finish_run();
    end

endmodule